// File: doc/BRIEF.md
# DRAM Refresh Keeper

The refresh keeper sits beside an SDRAM command controller and makes sure the memory gets enough auto-refresh commands in every retention window. A free-running interval timer adds one "owed" refresh every average refresh interval. The default interval is 7.8 µs: 8192 refreshes spread over 64 ms, converted to clocks from the clock-frequency parameter. The controller pays refreshes back whenever all banks are precharged. Up to `MAX_OWED` refreshes may be postponed. When the ledger reaches that limit, an urgent flag tells the controller to stop opening rows until a refresh has been taken. After each refresh, a recovery window of tRC (65 ns by default, rounded up to whole clocks) holds off the next request. The memory precharges itself at the end of an auto refresh, so no precharge follows.

The request/grant pair is a plain level handshake, not a data stream. `ref_req` stays high until the controller answers with `ref_grant` in the same cycle. The controller drives the refresh command on its registered command bus in the following cycle. A grant seen while `ref_req` is low is ignored.

For low-power sleep, the host raises `sleep_req`. The keeper then asks for a self-refresh entry, flagged by `ref_self`, and drops `cke` in the cycle the refresh encoding is on the bus. When `sleep_req` falls, `cke` returns high. One clock later the keeper requests a single recovery auto refresh before normal traffic resumes.

Top module: `dram_refresh_keeper`

## Requirements
- R1: Reset, whether asleep or not, drives `ref_req`=0, `ref_urgent`=0, `ref_owed`=0 and `cke`=1.
- R2: The ledger gains one owed refresh every REFI_CLK = CLK_MHZ*REFI_NS/1000 clocks while awake; the first increase appears REFI_CLK clock edges after reset is released.
- R3: `ref_req` is high only while awake, `banks_idle`=1, the recovery window has elapsed and something is pending (owed refresh, sleep request or recovery refresh); with an owed refresh and idle banks it is high in the same cycle.
- R4: An accepted grant (`ref_req` and `ref_grant` both 1) lowers `ref_owed` by one at the next edge; if an interval tick lands on the same edge the count is unchanged.
- R5: After an accepted auto-refresh grant, `ref_req` stays low for TRC_CLK = ceil(CLK_MHZ*TRC_NS/1000) cycles and may rise on the edge after that.
- R6: `ref_owed` never exceeds MAX_OWED; `ref_urgent` is 1 exactly when `ref_owed` equals MAX_OWED, and further ticks at the limit leave the count at MAX_OWED.
- R7: `ref_grant` while `ref_req` is low changes neither `ref_owed` nor the recovery window.
- R8: With `sleep_req`=1, the request carries `ref_self`=1; accepting it drives `cke` low at the next edge and clears `ref_owed` to 0.
- R9: While asleep, `cke` stays 0, `ref_req` stays 0 and `ref_owed` does not grow, whatever `banks_idle` and `ref_grant` do.
- R10: When `sleep_req` falls, `cke` rises at the next edge with `ref_req` still low, and a request with `ref_self`=0 appears one edge later.
- R11: The recovery refresh after wake-up does not alter `ref_owed`; once it is granted no further request appears while nothing is owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| banks_idle | input | 1 | All banks are in the precharged state |
| sleep_req | input | 1 | Host level request for self-refresh sleep |
| ref_grant | input | 1 | Controller accepts the pending request this cycle |
| ref_req | output | 1 | Refresh or self-refresh entry wanted |
| ref_self | output | 1 | The pending request is a self-refresh entry |
| ref_urgent | output | 1 | Postponement limit reached; hold off activates |
| ref_owed | output | OWED_W (4) | Number of postponed refreshes |
| cke | output | 1 | Clock enable to the memory |

## Verification
Every cycle, the assertions check the following relations:
- a request never appears with busy banks or while asleep;
- an auto-refresh grant always silences the request for the next cycle;
- a ledger payment removes exactly one refresh;
- the count never passes its cap;
- `cke` only falls right after an accepted self-refresh request;
- no request coexists with the cycle in which `cke` rises.

Only the bench scenarios can show the exact tick spacing and the saturation at the cap. The same holds for the cancellation of a tick by a simultaneous grant, the exact length of the recovery window, and a stray grant leaving the window untouched. The one-cycle gap before the wake-up refresh and the reset of `cke` from inside sleep are also left to the scenarios.

// File: rtl/refkeep_pkg.sv
package refkeep_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WAKE  = 2'd2
  } keep_state_t;
endpackage

// File: rtl/refi_timer.sv
// Free-running average-interval timer; emits a one-cycle tick every INTERVAL
// clocks while run is high and restarts from a full interval when stopped.
module refi_timer #(
  parameter int INTERVAL = 1037
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= RELOAD;
    end else if (cnt == '0) begin
      cnt <= RELOAD;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign tick = run && (cnt == '0);

  // R2: the count never leaves its legal range
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= RELOAD);
endmodule

// File: rtl/owe_ledger.sv
// Saturating count of postponed refreshes.
module owe_ledger #(
  parameter int MAX_OWED = 8,
  parameter int OWED_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              inc,
  input  logic              dec,
  output logic [OWED_W-1:0] owed,
  output logic              urgent
);
  localparam logic [OWED_W-1:0] CAP = OWED_W'(MAX_OWED);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      owed <= '0;
    end else begin
      unique case ({inc, dec})
        2'b10:   if (owed != CAP) owed <= owed + 1'b1;
        2'b01:   if (owed != '0)  owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end

  assign urgent = (owed == CAP);

  assert_owed_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= CAP);

  assert_pay_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && !clear && owed != '0) |=> (owed == $past(owed) - 1'b1));

  assert_tick_cancel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && inc && !clear) |=> $stable(owed));
endmodule

// File: rtl/trc_guard.sv
// Recovery window after an auto refresh: ready drops for HOLD cycles.
module trc_guard #(
  parameter int HOLD = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ready
);
  localparam int W = $clog2(HOLD + 1);
  localparam logic [W-1:0] LOAD = W'(HOLD);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= LOAD;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign ready = (cnt == '0);

  assert_trc_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready);
endmodule

// File: rtl/dram_refresh_keeper.sv
module dram_refresh_keeper #(
  parameter int CLK_MHZ  = 133,
  parameter int REFI_NS  = 7800,
  parameter int TRC_NS   = 65,
  parameter int MAX_OWED = 8,
  parameter int OWED_W   = $clog2(MAX_OWED + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              banks_idle,
  input  logic              sleep_req,
  input  logic              ref_grant,
  output logic              ref_req,
  output logic              ref_self,
  output logic              ref_urgent,
  output logic [OWED_W-1:0] ref_owed,
  output logic              cke
);
  import refkeep_pkg::*;

  localparam int REFI_CLK = (CLK_MHZ * REFI_NS) / 1000;
  localparam int TRC_CLK  = (CLK_MHZ * TRC_NS + 999) / 1000;

  keep_state_t state;
  logic wake_pend;
  logic tick, trc_ready;
  logic awake, pending, issue, issue_auto, issue_self;

  assign awake   = (state == ST_RUN);
  assign pending = wake_pend || sleep_req || (ref_owed != '0);
  assign ref_req = awake && banks_idle && trc_ready && pending;
  assign ref_self = ref_req && sleep_req && !wake_pend;

  assign issue      = ref_req && ref_grant;
  assign issue_self = issue && ref_self;
  assign issue_auto = issue && !ref_self;

  refi_timer #(.INTERVAL(REFI_CLK)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (awake),
    .tick (tick)
  );

  owe_ledger #(.MAX_OWED(MAX_OWED), .OWED_W(OWED_W)) u_ledger (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (issue_self),
    .inc   (tick),
    .dec   (issue_auto && !wake_pend),
    .owed  (ref_owed),
    .urgent(ref_urgent)
  );

  trc_guard #(.HOLD(TRC_CLK)) u_trc (
    .clk  (clk),
    .rst_n(rst_n),
    .start(issue_auto),
    .ready(trc_ready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_RUN;
      cke       <= 1'b1;
      wake_pend <= 1'b0;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (issue_self) begin
            state <= ST_SLEEP;
            cke   <= 1'b0;
          end
          if (issue_auto && wake_pend) wake_pend <= 1'b0;
        end
        ST_SLEEP: begin
          if (!sleep_req) begin
            state <= ST_WAKE;
            cke   <= 1'b1;
          end
        end
        ST_WAKE: begin
          state     <= ST_RUN;
          wake_pend <= 1'b1;
        end
        default: begin
          state <= ST_RUN;
          cke   <= 1'b1;
        end
      endcase
    end
  end

  assert_req_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> (banks_idle && cke));

  assert_cke_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> $past(ref_req && ref_grant && ref_self));

  assert_sleep_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke) |-> (!ref_req && ref_owed == '0));

  assert_wake_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> !ref_req);
endmodule

// File: tb/sim_dram_refresh_keeper.sv
`timescale 1ns/100ps
module sim_dram_refresh_keeper;
  // 100 MHz parameters give a 40-clock interval and a 7-clock recovery window
  localparam int REFI = 40;
  localparam int TRC  = 7;

  logic clk = 1'b0;
  logic rst_n, banks_idle, sleep_req, ref_grant;
  logic ref_req, ref_self, ref_urgent, cke;
  logic [3:0] ref_owed;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dram_refresh_keeper #(.CLK_MHZ(100), .REFI_NS(400), .TRC_NS(65), .MAX_OWED(8)) u0 (
    .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .sleep_req(sleep_req),
    .ref_grant(ref_grant), .ref_req(ref_req), .ref_self(ref_self),
    .ref_urgent(ref_urgent), .ref_owed(ref_owed), .cke(cke)
  );

  typedef struct packed {
    logic        idle;
    logic        grant;
    logic [15:0] ncyc;
    logic [3:0]  owed;
    logic        req;
    logic        urg;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 16'd39,  4'd0, 1'b0, 1'b0, 4'd2},  // R2 edge 39: nothing owed yet
    '{1'b0, 1'b0, 16'd1,   4'd1, 1'b0, 1'b0, 4'd2},  // R2 edge 40: first tick; R3 busy banks
    '{1'b1, 1'b0, 16'd0,   4'd1, 1'b1, 1'b0, 4'd3},  // R3 idle banks raise request
    '{1'b1, 1'b1, 16'd1,   4'd0, 1'b0, 1'b0, 4'd4},  // R4 edge 41 grant pays
    '{1'b0, 1'b0, 16'd278, 4'd6, 1'b0, 1'b0, 4'd2},  // R2 edge 319
    '{1'b0, 1'b0, 16'd1,   4'd7, 1'b0, 1'b0, 4'd2},  // R2 edge 320
    '{1'b0, 1'b0, 16'd40,  4'd8, 1'b0, 1'b1, 4'd6},  // R6 cap reached
    '{1'b0, 1'b0, 16'd40,  4'd8, 1'b0, 1'b1, 4'd6},  // R6 saturates
    '{1'b1, 1'b1, 16'd1,   4'd7, 1'b0, 1'b0, 4'd4},  // R4 edge 401
    '{1'b1, 1'b0, 16'd6,   4'd7, 1'b0, 1'b0, 4'd5},  // R5 window still closed
    '{1'b1, 1'b0, 16'd1,   4'd7, 1'b1, 1'b0, 4'd5},  // R5 opens after TRC cycles
    '{1'b1, 1'b1, 16'd1,   4'd6, 1'b0, 1'b0, 4'd4},  // R4 edge 409
    '{1'b1, 1'b0, 16'd30,  4'd6, 1'b1, 1'b0, 4'd3}   // R3 edge 439 pending
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; banks_idle = 1'b0; sleep_req = 1'b0; ref_grant = 1'b0;
    adv(3);
    chk("R1 req", ref_req, 0);
    chk("R1 owed", ref_owed, 0);
    chk("R1 urgent", ref_urgent, 0);
    chk("R1 cke", cke, 1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      banks_idle = VECS[i].idle;
      ref_grant  = VECS[i].grant;
      adv(int'(VECS[i].ncyc));
      if (ref_owed !== VECS[i].owed || ref_req !== VECS[i].req || ref_urgent !== VECS[i].urg) begin
        total++;
        fails++;
        $display("FAIL R%0d row %0d actual owed=%0d req=%0d urg=%0d expected owed=%0d req=%0d urg=%0d",
                 VECS[i].rq, i, ref_owed, ref_req, ref_urgent, VECS[i].owed, VECS[i].req, VECS[i].urg);
      end else begin
        total++;
      end
    end

    // R4: grant on the tick edge (440) cancels the tick
    ref_grant = 1'b1; adv(1);
    chk("R4 owed on tick edge", ref_owed, 6);
    chk("R4 req after grant", ref_req, 0);

    // R7: grant inside the recovery window does nothing
    adv(1);
    chk("R7 owed", ref_owed, 6);
    ref_grant = 1'b0; adv(5);
    chk("R7 window not reloaded (closed)", ref_req, 0);
    adv(1);
    chk("R7 window not reloaded (open)", ref_req, 1);
    banks_idle = 1'b0; ref_grant = 1'b1; adv(1);
    chk("R7 busy grant owed", ref_owed, 6);
    chk("R7 busy grant req", ref_req, 0);

    // R8: self-refresh entry
    banks_idle = 1'b1; ref_grant = 1'b0; sleep_req = 1'b1; adv(0);
    chk("R8 req", ref_req, 1);
    chk("R8 self flag", ref_self, 1);
    ref_grant = 1'b1; adv(1);
    chk("R8 cke low", cke, 0);
    chk("R8 owed cleared", ref_owed, 0);

    // R9: quiet while asleep across several intervals
    adv(3 * REFI);
    chk("R9 cke", cke, 0);
    chk("R9 req", ref_req, 0);
    chk("R9 owed", ref_owed, 0);

    // R10: exit
    ref_grant = 1'b0; sleep_req = 1'b0; adv(1);
    chk("R10 cke high", cke, 1);
    chk("R10 req held", ref_req, 0);
    adv(1);
    chk("R10 recovery req", ref_req, 1);
    chk("R10 self flag", ref_self, 0);

    // R11: recovery refresh leaves the ledger alone
    ref_grant = 1'b1; adv(1);
    chk("R11 owed", ref_owed, 0);
    chk("R11 req", ref_req, 0);
    ref_grant = 1'b0; adv(TRC + 1);
    chk("R11 no further req", ref_req, 0);

    // R1: reset from inside sleep
    sleep_req = 1'b1; ref_grant = 1'b1; adv(1);
    chk("R8 second entry cke", cke, 0);
    rst_n = 1'b0; sleep_req = 1'b0; ref_grant = 1'b0; adv(1);
    chk("R1 cke from sleep", cke, 1);
    chk("R1 req from sleep", ref_req, 0);
    chk("R1 owed from sleep", ref_owed, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule